// File: doc/BRIEF.md
# Two-Channel Offset Calibration Sequencer

This block removes the DC offset that a converter front end adds to its left and right sample streams. When the active-low power-down input is released after a proper low pulse, and calibration is enabled through its own active-low input, the block opens a measurement window of 4096 sample strobes. For the whole window the calibration flag is high, so it can close an external switch that grounds the analog inputs, and every output sample is forced to zero. Over the last 256 strobes of the window it accumulates each channel and stores the floor average as that channel's offset.

From then on each incoming sample has its channel's stored offset subtracted, with the result clamped to the 20-bit two's-complement range. If calibration is disabled at the release, no window runs and the stored offsets are cleared, so samples pass through unchanged. A release after a pulse that is too short is taken as a glitch: it runs no window and keeps the offsets.

The sequencer has three states. PWRDN is held while the power-down input is low. PWRDN goes to MEASURE on a qualified release with calibration enabled. PWRDN goes to STREAM on any other release: with the offsets cleared after a qualified release, or with the offsets kept after a short pulse. MEASURE goes to STREAM on the strobe that closes the window. Any state goes to PWRDN when the power-down input is low.

Top module: `offset_cal_seq`

## Requirements
- R1: On the clock edge after pwr_dn_n is sampled low, out_l and out_r are zero and cal_flag is low. They stay that way while pwr_dn_n remains low.
- R2: A rising pwr_dn_n that follows at least 3 consecutive clocks sampled low, with cal_en_n low, starts a window. cal_flag goes high on the first clock edge that samples pwr_dn_n high.
- R3: A rising pwr_dn_n that follows only 1 or 2 low clocks runs no window, leaves cal_flag low and keeps the stored offsets.
- R4: A window covers exactly 4096 smp_vld strobes. cal_flag falls on the clock edge that takes the 4096th strobe.
- R5: Every output update caused by a strobe taken while cal_flag is high is zero on both channels.
- R6: Each channel's stored offset is the sum of that channel's samples from the last 256 strobes of the window, arithmetically shifted right by 8 (floor division).
- R7: After a window, each strobe sets out_l = smp_l − offset_l and out_r = smp_r − offset_r, with the channels independent. The first strobe after cal_flag falls already yields a corrected value.
- R8: The difference saturates to 0x7FFFF (maximum) or 0x80000 (minimum) and never wraps.
- R9: A qualified release with cal_en_n high runs no window and clears both offsets to zero, so outputs equal inputs.
- R10: out_stb is a one-clock pulse on the clock edge after smp_vld, and the data outputs change only on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_dn_n | input | 1 | Active-low power-down; its release starts calibration |
| cal_en_n | input | 1 | Active-low calibration enable, sampled at release |
| smp_vld | input | 1 | One-clock strobe marking a new sample pair |
| smp_l | input | 20 | Left sample, two's complement |
| smp_r | input | 20 | Right sample, two's complement |
| out_stb | output | 1 | Strobe for the corrected output pair |
| out_l | output | 20 | Corrected left sample |
| out_r | output | 20 | Corrected right sample |
| cal_flag | output | 1 | High during the measurement window |

## Verification
The hardest condition to reach from the ports is the window boundary: the flag must fall on exactly the 4096th strobe, and the average must use only the final 256 samples. The bench therefore drives a full window of random noise around fixed per-channel offsets and keeps its own running sum of the trailing 256 samples. It checks the flag on the 4095th and the 4096th strobe. It then chooses input extremes against offsets of opposite sign to force both saturation limits, and sends a two-clock power-down glitch to show that the offsets survive it.

// File: rtl/ocs_pkg.sv
package ocs_pkg;

    typedef enum logic [1:0] {
        ST_PWRDN   = 2'd0,
        ST_MEASURE = 2'd1,
        ST_STREAM  = 2'd2
    } ocs_state_e;

endpackage

// File: rtl/ocs_release_qual.sv
module ocs_release_qual #(
    parameter int PD_MIN = 3
) (
    input  logic clk,
    input  logic pwr_dn_n,
    output logic release_ok
);
    localparam int CW = $clog2(PD_MIN + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!pwr_dn_n) begin
            if (low_cnt != CW'(PD_MIN)) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end else begin
            low_cnt <= '0;
        end
    end

    assign release_ok = pwr_dn_n && (low_cnt >= CW'(PD_MIN));

endmodule

// File: rtl/ocs_chan.sv
module ocs_chan #(
    parameter int DATA_W   = 20,
    parameter int AVG_LOG2 = 8
) (
    input  logic                     clk,
    input  logic                     acc_clr,
    input  logic                     acc_add,
    input  logic                     off_load,
    input  logic                     off_clr,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] off
);
    localparam int ACC_W = DATA_W + AVG_LOG2;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sum_nxt;

    assign sum_nxt = acc + {{AVG_LOG2{din[DATA_W-1]}}, din};

    always_ff @(posedge clk) begin
        if (acc_clr) begin
            acc <= '0;
        end else if (acc_add) begin
            acc <= sum_nxt;
        end
    end

    // Upper slice of the sum is the arithmetic right shift by AVG_LOG2.
    always_ff @(posedge clk) begin
        if (off_clr) begin
            off <= '0;
        end else if (off_load) begin
            off <= sum_nxt[ACC_W-1:AVG_LOG2];
        end
    end

endmodule

// File: rtl/ocs_subsat.sv
module ocs_subsat #(
    parameter int DATA_W = 20
) (
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic signed [DATA_W-1:0] y
);
    localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W:0] diff;
    logic                   ovf;

    assign diff = {a[DATA_W-1], a} - {b[DATA_W-1], b};
    assign ovf  = diff[DATA_W] != diff[DATA_W-1];

    always_comb begin
        if (ovf) begin
            y = diff[DATA_W] ? MIN_V : MAX_V;
        end else begin
            y = diff[DATA_W-1:0];
        end
    end

    always_comb begin
        if (!a[DATA_W-1] && b[DATA_W-1]) begin
            AST_NO_WRAP_POS: assert (!y[DATA_W-1]); // R8
        end
        if (a[DATA_W-1] && !b[DATA_W-1]) begin
            AST_NO_WRAP_NEG: assert (y[DATA_W-1]); // R8
        end
    end

endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
    import ocs_pkg::*;
#(
    parameter int DATA_W   = 20,
    parameter int WIN_LEN  = 4096,
    parameter int AVG_LOG2 = 8,
    parameter int PD_MIN   = 3
) (
    input  logic              clk,
    input  logic              pwr_dn_n,
    input  logic              cal_en_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_l,
    input  logic [DATA_W-1:0] smp_r,
    output logic              out_stb,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r,
    output logic              cal_flag
);
    localparam int NCH       = 2;
    localparam int WIN_W     = $clog2(WIN_LEN);
    localparam int AVG_LEN   = 2 ** AVG_LOG2;
    localparam int AVG_START = WIN_LEN - AVG_LEN;

    ocs_state_e state, state_nx;

    logic              release_ok;
    logic [WIN_W-1:0]  win_cnt;
    logic              win_last;
    logic              in_avg;
    logic              acc_clr, acc_add, off_load, off_clr;

    logic signed [DATA_W-1:0] din_a  [NCH];
    logic signed [DATA_W-1:0] off_a  [NCH];
    logic signed [DATA_W-1:0] corr_a [NCH];
    logic        [DATA_W-1:0] out_a  [NCH];

    assign din_a[0] = smp_l;
    assign din_a[1] = smp_r;
    assign out_l    = out_a[0];
    assign out_r    = out_a[1];

    ocs_release_qual #(.PD_MIN(PD_MIN)) u_qual (
        .clk        (clk),
        .pwr_dn_n   (pwr_dn_n),
        .release_ok (release_ok)
    );

    assign win_last = win_cnt == WIN_W'(WIN_LEN - 1);
    assign in_avg   = win_cnt >= WIN_W'(AVG_START);

    always_comb begin
        state_nx = state;
        if (!pwr_dn_n) begin
            state_nx = ST_PWRDN;
        end else begin
            unique case (state)
                ST_PWRDN:   state_nx = (release_ok && !cal_en_n) ? ST_MEASURE : ST_STREAM;
                ST_MEASURE: state_nx = (smp_vld && win_last) ? ST_STREAM : ST_MEASURE;
                ST_STREAM:  state_nx = ST_STREAM;
                default:    state_nx = ST_PWRDN;
            endcase
        end
    end

    assign acc_clr  = state == ST_PWRDN;
    assign acc_add  = (state == ST_MEASURE) && smp_vld && in_avg;
    assign off_load = (state == ST_MEASURE) && smp_vld && win_last && pwr_dn_n;
    assign off_clr  = (state == ST_PWRDN) && release_ok && cal_en_n;

    // State register and window counter
    always_ff @(posedge clk) begin
        state <= state_nx;
        if (state != ST_MEASURE) begin
            win_cnt <= '0;
        end else if (smp_vld) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ocs_chan #(.DATA_W(DATA_W), .AVG_LOG2(AVG_LOG2)) u_chan (
            .clk      (clk),
            .acc_clr  (acc_clr),
            .acc_add  (acc_add),
            .off_load (off_load),
            .off_clr  (off_clr),
            .din      (din_a[c]),
            .off      (off_a[c])
        );

        ocs_subsat #(.DATA_W(DATA_W)) u_sub (
            .a (din_a[c]),
            .b (off_a[c]),
            .y (corr_a[c])
        );
    end

    // Output register
    always_ff @(posedge clk) begin
        out_stb  <= smp_vld;
        cal_flag <= state_nx == ST_MEASURE;
        for (int c = 0; c < NCH; c++) begin
            if (!pwr_dn_n) begin
                out_a[c] <= '0;
            end else if (smp_vld) begin
                out_a[c] <= (state == ST_STREAM) ? corr_a[c] : '0;
            end
        end
    end

    AST_PWRDN_ZERO: assert property (@(posedge clk) disable iff (!pwr_dn_n)
        $past(!pwr_dn_n) |-> (out_l == '0 && out_r == '0 && !cal_flag)); // R1

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!pwr_dn_n)
        $rose(cal_flag) |-> $past(!cal_en_n)); // R2

    AST_FLAG_FALL_ON_STB: assert property (@(posedge clk) disable iff (!pwr_dn_n)
        $fell(cal_flag) |-> ($past(smp_vld) || $past(!pwr_dn_n))); // R4

    AST_WINDOW_ZERO: assert property (@(posedge clk) disable iff (!pwr_dn_n)
        (cal_flag && smp_vld) |=> (out_l == '0 && out_r == '0)); // R5

    AST_STB_LATENCY: assert property (@(posedge clk) disable iff (!pwr_dn_n)
        smp_vld |=> out_stb); // R10

    AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!pwr_dn_n)
        (!smp_vld && $past(pwr_dn_n)) |=> ($stable(out_l) && $stable(out_r))); // R10

endmodule

// File: tb/sim_offset_cal_seq.sv
module sim_offset_cal_seq;
    localparam int  CLK_P = 10;
    localparam int  DW    = 20;
    localparam int  WIN   = 4096;
    localparam int  AVGN  = 256;

    logic          clk = 1'b0;
    logic          pwr_dn_n = 1'b0;
    logic          cal_en_n = 1'b1;
    logic          smp_vld = 1'b0;
    logic [DW-1:0] smp_l = '0;
    logic [DW-1:0] smp_r = '0;
    logic          out_stb;
    logic [DW-1:0] out_l, out_r;
    logic          cal_flag;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    longint off_l = 0, off_r = 0;

    always #(CLK_P/2) clk = ~clk;

    offset_cal_seq u0 (
        .clk(clk), .pwr_dn_n(pwr_dn_n), .cal_en_n(cal_en_n),
        .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
        .out_stb(out_stb), .out_l(out_l), .out_r(out_r), .cal_flag(cal_flag)
    );

    function automatic longint sx(input logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint sat_sub(input longint a, input longint b);
        longint d = a - b;
        if (d > 524287)  return 524287;
        if (d < -524288) return -524288;
        return d;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Drive one strobe; after it, outputs are compared at the next negedge.
    task automatic send(input logic [DW-1:0] l, input logic [DW-1:0] r,
                        input bit chk, input longint el, input longint er, input string req);
        @(negedge clk);
        smp_vld = 1'b1; smp_l = l; smp_r = r;
        @(negedge clk);
        smp_vld = 1'b0;
        if (chk) begin
            check(req, sx(out_l), el);
            check(req, sx(out_r), er);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic power_down(input int cyc);
        @(negedge clk);
        pwr_dn_n = 1'b0;
        repeat (cyc) @(negedge clk);
        pwr_dn_n = 1'b1;
    endtask

    task automatic run_random(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0] l = DW'($urandom());
            logic [DW-1:0] r = DW'($urandom());
            send(l, r, 1'b1, sat_sub(sx(l), off_l), sat_sub(sx(r), off_r), req);
        end
    endtask

    initial begin
        void'($urandom(32'd1760));
        // Reset state: power-down held low
        repeat (3) @(negedge clk);
        check("R1 out_l in power-down", sx(out_l), 0);
        check("R1 flag in power-down", longint'(cal_flag), 0);

        // R9: release with calibration disabled
        cal_en_n = 1'b1;
        pwr_dn_n = 1'b1;
        @(negedge clk);
        check("R9 no window", longint'(cal_flag), 0);
        off_l = 0; off_r = 0;
        run_random(10, "R9 pass-through");

        // R10: strobe latency and hold
        @(negedge clk);
        smp_vld = 1'b1; smp_l = 20'h00123; smp_r = 20'hFFF00;
        @(negedge clk);
        smp_vld = 1'b0;
        check("R10 out_stb pulse", longint'(out_stb), 1);
        smp_l = 20'h55555;
        @(negedge clk);
        check("R10 out_stb low", longint'(out_stb), 0);
        check("R10 hold without strobe", sx(out_l), 'h123);

        // R1: power-down during streaming forces zero
        @(negedge clk);
        pwr_dn_n = 1'b0;
        @(negedge clk);
        check("R1 zero after pd low", sx(out_r), 0);
        repeat (3) @(negedge clk);

        // R2: qualified release with calibration enabled
        cal_en_n = 1'b0;
        pwr_dn_n = 1'b1;
        @(negedge clk);
        check("R2 flag high", longint'(cal_flag), 1);
        begin
            longint sum_l = 0, sum_r = 0;
            for (int i = 0; i < WIN; i++) begin
                int nl = int'($urandom_range(0, 127)) - 64;
                int nr = int'($urandom_range(0, 255)) - 128;
                longint vl = 1234 + nl;
                longint vr = -2345 + nr;
                if (i >= WIN - AVGN) begin
                    sum_l += vl; sum_r += vr;
                end
                send(DW'(vl), DW'(vr), 1'b1, 0, 0, "R5 zero in window");
                if (i == WIN - 2) check("R4 flag before last", longint'(cal_flag), 1);
                if (i == WIN - 1) check("R4 flag after last", longint'(cal_flag), 0);
            end
            off_l = sum_l >>> 8;
            off_r = sum_r >>> 8;
        end
        // R6/R7: first strobe after window is corrected
        send(20'h00000, 20'h00000, 1'b1, sat_sub(0, off_l), sat_sub(0, off_r), "R6 offset average");
        run_random(40, "R7 corrected stream");

        // R8: saturation corners (off_l > 0, off_r < 0)
        send(20'h80000, 20'h7FFFF, 1'b1, -524288, 524287, "R8 saturation");
        send(20'h80005, 20'h7FFF0, 1'b1, sat_sub(sx(20'h80005), off_l),
             sat_sub(sx(20'h7FFF0), off_r), "R8 near limit");

        // R3: two-clock glitch keeps offsets
        power_down(2);
        @(negedge clk);
        check("R3 no window on short pulse", longint'(cal_flag), 0);
        run_random(10, "R3 offsets kept");

        // R9 again: qualified release, disabled, clears offsets
        cal_en_n = 1'b1;
        power_down(4);
        @(negedge clk);
        check("R9 no window", longint'(cal_flag), 0);
        off_l = 0; off_r = 0;
        run_random(10, "R9 offsets cleared");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule